// File: doc/BRIEF.md
# Floating-Point Execution Unit Timing Model

This block models the timing of the floating-point execution resources that sit between issue and writeback in a simple in-order pipeline. It contains one adder and one multiplier, neither duplicated. Each one tells the issue logic whether it can accept an operation in the current cycle. It carries every accepted operation through its latency and then raises a completion strobe with the operation's destination register tag, so the result can be written back at once. A separate single-cycle copy unit passes a tag straight through in one cycle and is always free.

No arithmetic is performed. An operation is a token that holds the destination tag, and the block's job is to decide when that token may enter and when it comes out. A profile input selects one of two timing sets. In the strong profile the adder takes 2 cycles and is fully pipelined, and the multiplier takes 4 cycles and can accept a new operation every 2 cycles. In the weak profile the adder takes 2 cycles and the multiplier takes 6 cycles, and neither is pipelined. The issue stage offers an operation by raising a request together with a tag. The offer is taken only in a cycle where that unit's ready output is high.

Top module: `fp_exec_units`

## Requirements
- R1: With `strong_fp`=1 the adder's ready output stays high in every cycle after reset. An add accepted in cycle c raises `add_done` in cycle c+2 with the same tag, and back-to-back adds complete back to back.
- R2: With `strong_fp`=0 the adder's ready output is low in the cycle after an accept and high again in cycle c+2, which is also the cycle in which that add completes.
- R3: With `strong_fp`=1 a multiply accepted in cycle c raises `mul_done` in cycle c+4 with its tag.
- R4: With `strong_fp`=1 the multiplier's ready output is low in cycle c+1 after an accept in cycle c, and high again from cycle c+2.
- R5: With `strong_fp`=0 a multiply accepted in cycle c completes in cycle c+6, and the multiplier's ready output is low from cycle c+1 through c+5.
- R6: The copy unit accepts a request in every cycle. A copy requested in cycle c raises `mov_done` in cycle c+1 with its tag.
- R7: A request made while that unit's ready output is low is dropped. It never produces a completion strobe.
- R8: Completion strobes of different units are independent, so the adder and the multiplier may both complete in the same cycle.
- R9: A synchronous reset (`rst`=1, active high) discards every operation in flight. In the first cycle after reset every ready output is high and no completion strobe is raised. Operations accepted before the reset never complete.
- R10: Each operation keeps the latency of the profile that was in force when it was accepted, even if `strong_fp` changes while it is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strong_fp | input | 1 | Profile select: 1 = strong, 0 = weak |
| add_issue | input | 1 | Adder request |
| add_tag | input | TAG_W | Destination tag of the add |
| add_ready | output | 1 | Adder can accept this cycle |
| add_done | output | 1 | Add completes this cycle |
| add_done_tag | output | TAG_W | Tag of the completing add |
| mul_issue | input | 1 | Multiplier request |
| mul_tag | input | TAG_W | Destination tag of the multiply |
| mul_ready | output | 1 | Multiplier can accept this cycle |
| mul_done | output | 1 | Multiply completes this cycle |
| mul_done_tag | output | TAG_W | Tag of the completing multiply |
| mov_issue | input | 1 | Copy request |
| mov_tag | input | TAG_W | Destination tag of the copy |
| mov_done | output | 1 | Copy completes this cycle |
| mov_done_tag | output | TAG_W | Tag of the completing copy |

## Verification
All in-flight state is held in per-stage valid bits and tags. A bad bit shows at the ports in one of two ways. It can drop the ready output in the very next cycle, or it can produce a missing, extra or mistagged completion strobe no later than the unit's latency, which is at most six cycles. The bench sweeps every 8-bit request pattern in both profiles. It predicts ready, completion cycle and tag from the last accept time and the profile latencies, so a state error is reported within one issue window.

// File: rtl/fp_exec_units.sv
module fp_exec_units #(
  parameter int TAG_W     = 5,
  parameter int ADD_LAT_S = 2,
  parameter int ADD_LAT_W = 2,
  parameter int ADD_II_S  = 1,
  parameter int MUL_LAT_S = 4,
  parameter int MUL_LAT_W = 6,
  parameter int MUL_II_S  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strong_fp,
  input  logic             add_issue,
  input  logic [TAG_W-1:0] add_tag,
  output logic             add_ready,
  output logic             add_done,
  output logic [TAG_W-1:0] add_done_tag,
  input  logic             mul_issue,
  input  logic [TAG_W-1:0] mul_tag,
  output logic             mul_ready,
  output logic             mul_done,
  output logic [TAG_W-1:0] mul_done_tag,
  input  logic             mov_issue,
  input  logic [TAG_W-1:0] mov_tag,
  output logic             mov_done,
  output logic [TAG_W-1:0] mov_done_tag
);
  localparam int ADD_D  = (ADD_LAT_S > ADD_LAT_W) ? ADD_LAT_S : ADD_LAT_W;
  localparam int MUL_D  = (MUL_LAT_S > MUL_LAT_W) ? MUL_LAT_S : MUL_LAT_W;
  localparam int ADD_JS = ADD_D - ADD_LAT_S;
  localparam int ADD_JW = ADD_D - ADD_LAT_W;
  localparam int MUL_JS = MUL_D - MUL_LAT_S;
  localparam int MUL_JW = MUL_D - MUL_LAT_W;
  localparam int ADD_NS = ADD_JS + ADD_II_S - 1;
  localparam int ADD_NW = ADD_D - 1;
  localparam int MUL_NS = MUL_JS + MUL_II_S - 1;
  localparam int MUL_NW = MUL_D - 1;

  localparam logic [ADD_D-1:0] ADD_MS = ADD_D'((64'd1 << ADD_NS) - 64'd1);
  localparam logic [ADD_D-1:0] ADD_MW = ADD_D'((64'd1 << ADD_NW) - 64'd1);
  localparam logic [MUL_D-1:0] MUL_MS = MUL_D'((64'd1 << MUL_NS) - 64'd1);
  localparam logic [MUL_D-1:0] MUL_MW = MUL_D'((64'd1 << MUL_NW) - 64'd1);
  localparam logic [ADD_D-1:0] ADD_IS = ADD_D'(64'd1 << ADD_JS);
  localparam logic [ADD_D-1:0] ADD_IW = ADD_D'(64'd1 << ADD_JW);
  localparam logic [MUL_D-1:0] MUL_IS = MUL_D'(64'd1 << MUL_JS);
  localparam logic [MUL_D-1:0] MUL_IW = MUL_D'(64'd1 << MUL_JW);

  logic [ADD_D-1:0] add_v;
  logic [TAG_W-1:0] add_t [ADD_D];
  logic [ADD_D-1:0] add_ins;
  logic [MUL_D-1:0] mul_v;
  logic [TAG_W-1:0] mul_t [MUL_D];
  logic [MUL_D-1:0] mul_ins;
  logic             mov_v;
  logic [TAG_W-1:0] mov_t;

  assign add_ready = ~|(add_v & (strong_fp ? ADD_MS : ADD_MW));
  assign mul_ready = ~|(mul_v & (strong_fp ? MUL_MS : MUL_MW));
  assign add_ins   = (add_issue && add_ready) ? (strong_fp ? ADD_IS : ADD_IW) : '0;
  assign mul_ins   = (mul_issue && mul_ready) ? (strong_fp ? MUL_IS : MUL_IW) : '0;

  always_ff @(posedge clk) begin
    if (rst) add_v <= '0;
    else     add_v <= (add_v << 1) | add_ins;
    add_t[0] <= add_tag;
    for (int k = 1; k < ADD_D; k++)
      add_t[k] <= add_ins[k] ? add_tag : add_t[k-1];
  end

  always_ff @(posedge clk) begin
    if (rst) mul_v <= '0;
    else     mul_v <= (mul_v << 1) | mul_ins;
    mul_t[0] <= mul_tag;
    for (int k = 1; k < MUL_D; k++)
      mul_t[k] <= mul_ins[k] ? mul_tag : mul_t[k-1];
  end

  always_ff @(posedge clk) begin
    if (rst) mov_v <= 1'b0;
    else     mov_v <= mov_issue;
    mov_t <= mov_tag;
  end

  assign add_done     = add_v[ADD_D-1];
  assign add_done_tag = add_t[ADD_D-1];
  assign mul_done     = mul_v[MUL_D-1];
  assign mul_done_tag = mul_t[MUL_D-1];
  assign mov_done     = mov_v;
  assign mov_done_tag = mov_t;

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> add_ready && mul_ready && !add_done && !mul_done && !mov_done); // R9
  AST_ADD_WEAK_BUSY: assert property (@(posedge clk) disable iff (rst)
    add_issue && add_ready && !strong_fp |=> strong_fp || !add_ready); // R2
  AST_MUL_ISSUE_GAP: assert property (@(posedge clk) disable iff (rst)
    mul_issue && mul_ready |=> !mul_ready); // R4
  AST_MUL_DONE_SPACED: assert property (@(posedge clk) disable iff (rst)
    mul_done |=> !mul_done); // R3
endmodule

// File: tb/fp_exec_units_bench.sv
module fp_exec_units_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strong_fp = 1'b1;
  logic add_issue = 1'b0, mul_issue = 1'b0, mov_issue = 1'b0;
  logic [4:0] add_tag = '0, mul_tag = '0, mov_tag = '0;
  logic add_ready, add_done, mul_ready, mul_done, mov_done;
  logic [4:0] add_done_tag, mul_done_tag, mov_done_tag;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  fp_exec_units u_fp_exec_units (
    .clk(clk), .rst(rst), .strong_fp(strong_fp),
    .add_issue(add_issue), .add_tag(add_tag), .add_ready(add_ready),
    .add_done(add_done), .add_done_tag(add_done_tag),
    .mul_issue(mul_issue), .mul_tag(mul_tag), .mul_ready(mul_ready),
    .mul_done(mul_done), .mul_done_tag(mul_done_tag),
    .mov_issue(mov_issue), .mov_tag(mov_tag),
    .mov_done(mov_done), .mov_done_tag(mov_done_tag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; add_issue = 0; mul_issue = 0; mov_issue = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9: idle state in the first cycle after reset
    chk(add_ready && mul_ready, "R9", {add_ready, mul_ready}, 3);
    chk(!add_done && !mul_done && !mov_done, "R9", {add_done, mul_done, mov_done}, 0);
  endtask

  task automatic run_sweep(input bit prof, input logic [7:0] p);
    bit ea_v[48], em_v[48], ev_v[48], ia[48], im[48];
    int ea_t[48], em_t[48], ev_t[48];
    int last_a = -100;
    int last_m = -100;
    int alat = 2;
    int mlat = prof ? 4 : 6;
    int aii = prof ? 1 : 2;
    int mii = prof ? 2 : 6;
    bit ra, rm;
    for (int i = 0; i < 48; i++) begin
      ea_v[i] = 0; em_v[i] = 0; ev_v[i] = 0; ia[i] = 0; im[i] = 0;
      ea_t[i] = 0; em_t[i] = 0; ev_t[i] = 0;
    end
    strong_fp = prof;
    do_reset();
    for (int cyc = 0; cyc < 32; cyc++) begin
      @(negedge clk);
      if (cyc < 24) begin
        add_issue = p[(cyc + 3) % 8];
        mul_issue = p[cyc % 8];
        mov_issue = ~p[(cyc + 5) % 8];
      end else begin
        add_issue = 0; mul_issue = 0; mov_issue = 0;
      end
      add_tag = 5'(cyc);
      mul_tag = 5'(cyc + 7);
      mov_tag = 5'(cyc + 13);
      #1;
      ra = (cyc - last_a) >= aii;
      rm = (cyc - last_m) >= mii;
      chk(add_ready == ra, prof ? "R1" : "R2", add_ready, ra);
      chk(mul_ready == rm, prof ? "R4" : "R5", mul_ready, rm);
      if (add_issue && ra) begin last_a = cyc; ea_v[cyc+alat] = 1; ea_t[cyc+alat] = cyc % 32; end
      else if (add_issue) ia[cyc+alat] = 1;
      if (mul_issue && rm) begin last_m = cyc; em_v[cyc+mlat] = 1; em_t[cyc+mlat] = (cyc + 7) % 32; end
      else if (mul_issue) im[cyc+mlat] = 1;
      if (mov_issue) begin ev_v[cyc+1] = 1; ev_t[cyc+1] = (cyc + 13) % 32; end
      // R7: a dropped request must leave no strobe at its would-be completion cycle
      chk(add_done == ea_v[cyc], ia[cyc] ? "R7" : (prof ? "R1" : "R2"), add_done, ea_v[cyc]);
      if (ea_v[cyc]) chk(add_done_tag == ea_t[cyc], prof ? "R1" : "R2", add_done_tag, ea_t[cyc]);
      chk(mul_done == em_v[cyc], im[cyc] ? "R7" : (prof ? "R3" : "R5"), mul_done, em_v[cyc]);
      if (em_v[cyc]) chk(mul_done_tag == em_t[cyc], prof ? "R3" : "R5", mul_done_tag, em_t[cyc]);
      chk(mov_done == ev_v[cyc], "R6", mov_done, ev_v[cyc]);
      if (ev_v[cyc]) chk(mov_done_tag == ev_t[cyc], "R6", mov_done_tag, ev_t[cyc]);
      if (ea_v[cyc] && em_v[cyc]) chk(add_done && mul_done, "R8", {add_done, mul_done}, 3);
    end
  endtask

  initial begin
    for (int prof = 0; prof < 2; prof++)
      for (int p = 0; p < 256; p++)
        run_sweep(prof[0], 8'(p));

    // R9: reset during a weak multiply discards it
    strong_fp = 0;
    do_reset();
    @(negedge clk); mul_issue = 1; mul_tag = 5'd9;
    @(negedge clk); mul_issue = 0;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int k = 0; k < 8; k++) begin
      #1;
      chk(!mul_done, "R9", mul_done, 0);
      chk(mul_ready, "R9", mul_ready, 1);
      @(negedge clk);
    end

    // R10: profile change while a strong multiply is in flight
    strong_fp = 1;
    do_reset();
    @(negedge clk); mul_issue = 1; mul_tag = 5'd21;
    @(negedge clk); mul_issue = 0; strong_fp = 0;
    for (int k = 2; k < 9; k++) begin
      @(negedge clk); #1;
      chk(mul_done == (k == 4), "R10", mul_done, k == 4);
      if (k == 4) chk(mul_done_tag == 5'd21, "R10", mul_done_tag, 21);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule